// File: doc/BRIEF.md
# Burst-Four Byte-Masked Memory Write Port

This block is the write front end of a synchronous memory. On every rising clock edge it samples an address bus and two active-low command strobes, one for write and one for read. A write command loads the sampled address as the base of a fixed burst of four data beats. The beats arrive on an 18-bit data bus on the four edges that follow the command and are stored in a small on-chip array.

Each beat carries two 9-bit byte lanes. Each lane has its own active-low enable that is sampled together with that beat, so any lane of any beat can be kept out of the array. The burst address stays inside the four-word aligned group of the base address. A combinational debug port reads any stored word.

A read command is decoded only so that it can be told apart from a write. It starts nothing on the write path and does not disturb a burst that is already running. Because all beats share one data bus, a new write can only start on the edge that captures the final beat of the current burst.

Top module: `sqw_write_port`

## Requirements
- R1: On each rising edge, the block starts a write burst when `wr_ni` is 0, `rd_ni` is 1 and no lockout is active. With both strobes at 1 the edge is a no-operation and nothing is stored.
- R2: A read command (`rd_ni` 0, `wr_ni` 1) and the pattern with both strobes at 0 start no burst. On any edge of a running burst they leave the storage of the burst's beats unchanged.
- R3: `wr_ni` is ignored on the edge directly after an edge that accepted a write command.
- R4: `wr_ni` stays ignored on the second and third beat edges of a burst. A write command on the fourth beat edge is accepted, and its burst follows directly with no gap.
- R5: The data beats are captured on the four rising edges after the command edge. Beat k (k = 0..3) is written to the address whose upper bits equal the base address and whose two low bits are (base[1:0] + k) mod 4. Data presented outside a burst is not stored.
- R6: `bw_ni[0]` is sampled with each beat and, when 1, blocks data bits 8:0. `bw_ni[1]` does the same for bits 17:9. A blocked lane keeps its previous contents and an enabled lane takes the new data.
- R7: The lane masks of each beat are independent of the masks of the other beats of the same burst.
- R8: `rst_ni` low abandons any burst in progress and clears the lockout. Beats that would have followed are not stored, and the contents of the array are kept.
- R9: `dbg_data_o` shows, with no clock delay, the word stored at `dbg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the burst control |
| addr_i | input | ADDR_W (6) | Command address, base of the burst |
| wr_ni | input | 1 | Active-low write strobe |
| rd_ni | input | 1 | Active-low read strobe |
| data_i | input | 18 | Write data beat |
| bw_ni | input | 2 | Active-low byte-lane enables, one per 9-bit lane |
| dbg_addr_i | input | ADDR_W (6) | Debug read address |
| dbg_data_o | output | 18 | Word stored at `dbg_addr_i` |

## Verification
On every cycle the assertions check the command decode, the one-edge lockout after an accepted write, the end of a burst after its final beat, and that a lane whose mask is high never gets a write enable. The assertions cannot see addresses or stored values. Only the bench scenarios can show the following: the wrapped address order within the aligned group, the preservation of masked bytes, chaining on the final beat, the fate of ignored write strobes, and that a reset in the middle of a burst keeps the array contents. The bench does this by reading every word back through the debug port after each scenario.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int BYTE_W    = 9;
  localparam int N_LANES   = 2;
  localparam int DATA_W    = BYTE_W * N_LANES;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);
  localparam int LEFT_W    = $clog2(BURST_LEN + 1);

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_BOTH  = 2'b11
  } cmd_e;
endpackage

// File: rtl/sqw_cmd_dec.sv
module sqw_cmd_dec (
  input  logic wr_ni,
  input  logic rd_ni,
  input  logic lock_i,
  output logic accept_o
);
  import sqw_pkg::*;

  cmd_e cmd;

  always_comb begin
    cmd = cmd_e'({~rd_ni, ~wr_ni});
    unique case (cmd)
      CMD_WRITE: accept_o = ~lock_i;
      CMD_READ:  accept_o = 1'b0;  // placeholder, write path untouched
      CMD_BOTH:  accept_o = 1'b0;
      default:   accept_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sqw_burst_seq.sv
module sqw_burst_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              beat_vld_o,
  output logic              lock_o,
  output logic [ADDR_W-1:0] beat_addr_o
);
  import sqw_pkg::*;

  logic [LEFT_W-1:0] left_q;
  logic [BEAT_W-1:0] idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              prev_wr_q;

  assign beat_vld_o = (left_q != '0);
  // new command only on the final beat edge or when idle
  assign lock_o     = prev_wr_q | (left_q > LEFT_W'(1));
  assign beat_addr_o = {base_q[ADDR_W-1:BEAT_W], base_q[BEAT_W-1:0] + idx_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q    <= '0;
      idx_q     <= '0;
      prev_wr_q <= 1'b0;
    end else begin
      prev_wr_q <= accept_i;
      if (accept_i) begin
        left_q <= LEFT_W'(BURST_LEN);
        idx_q  <= '0;
      end else if (beat_vld_o) begin
        left_q <= left_q - LEFT_W'(1);
        idx_q  <= idx_q + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept_i) base_q <= addr_i;
  end
endmodule

// File: rtl/sqw_mem_array.sv
module sqw_mem_array #(
  parameter int ADDR_W  = 6,
  parameter int N_LANES = 2,
  parameter int BYTE_W  = 9
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [N_LANES*BYTE_W-1:0]   wr_data_i,
  input  logic [N_LANES-1:0]          bw_ni,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [N_LANES*BYTE_W-1:0]   rd_data_o,
  output logic [N_LANES-1:0]          lane_we_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];

    assign lane_we_o[l] = we_i & ~bw_ni[l];

    always_ff @(posedge clk_i) begin
      if (lane_we_o[l]) mem_q[wr_addr_i] <= wr_data_i[l*BYTE_W +: BYTE_W];
    end

    assign rd_data_o[l*BYTE_W +: BYTE_W] = mem_q[rd_addr_i];
  end
endmodule

// File: rtl/sqw_write_port.sv
module sqw_write_port #(
  parameter int ADDR_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_ni,
  input  logic                       rd_ni,
  input  logic [sqw_pkg::DATA_W-1:0] data_i,
  input  logic [sqw_pkg::N_LANES-1:0] bw_ni,
  input  logic [ADDR_W-1:0]          dbg_addr_i,
  output logic [sqw_pkg::DATA_W-1:0] dbg_data_o
);
  import sqw_pkg::*;

  logic              accept;
  logic              lock;
  logic              beat_vld;
  logic [ADDR_W-1:0] beat_addr;
  logic [N_LANES-1:0] lane_we;

  sqw_cmd_dec u_dec (
    .wr_ni    (wr_ni),
    .rd_ni    (rd_ni),
    .lock_i   (lock),
    .accept_o (accept)
  );

  sqw_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .addr_i      (addr_i),
    .beat_vld_o  (beat_vld),
    .lock_o      (lock),
    .beat_addr_o (beat_addr)
  );

  sqw_mem_array #(.ADDR_W(ADDR_W), .N_LANES(N_LANES), .BYTE_W(BYTE_W)) u_mem (
    .clk_i     (clk_i),
    .we_i      (beat_vld),
    .wr_addr_i (beat_addr),
    .wr_data_i (data_i),
    .bw_ni     (bw_ni),
    .rd_addr_i (dbg_addr_i),
    .rd_data_o (dbg_data_o),
    .lane_we_o (lane_we)
  );
endmodule

// File: rtl/sqw_write_port_chk.sv
module sqw_write_port_chk #(
  parameter int N_LANES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_ni,
  input logic               rd_ni,
  input logic [N_LANES-1:0] bw_ni,
  input logic               accept,
  input logic               lock,
  input logic               beat_vld,
  input logic [N_LANES-1:0] lane_we
);
  AST_DECODE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni || !rd_ni) |-> !accept);  // R1

  AST_READ_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_vld && lock && !rd_ni) |=> beat_vld);  // R2

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !accept);  // R3

  AST_BURST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_vld && !lock && !accept) |=> !beat_vld);  // R4

  AST_BEAT_FOLLOWS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> beat_vld);  // R5

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_vld |-> (lane_we == '0));  // R5

  for (genvar l = 0; l < N_LANES; l++) begin : g_mask
    AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bw_ni[l] |-> !lane_we[l]);  // R6
  end
endmodule

bind sqw_write_port sqw_write_port_chk #(.N_LANES(sqw_pkg::N_LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_ni    (wr_ni),
  .rd_ni    (rd_ni),
  .bw_ni    (bw_ni),
  .accept   (accept),
  .lock     (lock),
  .beat_vld (beat_vld),
  .lane_we  (lane_we)
);

// File: tb/sqw_write_port_test.sv
module sqw_write_port_test;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_ni = 1'b1;
  logic          rd_ni = 1'b1;
  logic [17:0]   data_i = '0;
  logic [1:0]    bw_ni = 2'b11;
  logic [AW-1:0] dbg_addr_i = '0;
  logic [17:0]   dbg_data_o;

  sqw_write_port #(.ADDR_W(AW)) uut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    int          a;
    logic [17:0] exp;
    string       tag;
  } item_t;

  item_t       q[$];
  int          n_run = 0;
  int          n_fail = 0;
  logic [17:0] ref_mem [DEPTH];
  int          rem = 0;
  int          idx = 0;
  int          base = 0;

  // monitor: reads back via the debug port and compares
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      it = q.pop_front();
      dbg_addr_i = AW'(it.a);
      #1;
      n_run++;
      if (dbg_data_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, dbg_data_o, it.exp);
      end
    end
  end

  // driver: one clock cycle, reference model updated at the edge
  task automatic step(input logic wn, input logic rn, input int a,
                      input logic [17:0] d, input logic [1:0] bw);
    bit acc;
    int wa;
    wr_ni = wn; rd_ni = rn; addr_i = AW'(a); data_i = d; bw_ni = bw;
    @(posedge clk_i);
    acc = (wn == 1'b0) && (rn == 1'b1) && (rem <= 1);
    if (rem > 0) begin
      wa = (base & ~3) | ((base + idx) & 3);
      if (!bw[0]) ref_mem[wa][8:0]  = d[8:0];
      if (!bw[1]) ref_mem[wa][17:9] = d[17:9];
      idx++;
      rem--;
    end
    if (acc) begin
      rem = 4; idx = 0; base = a;
    end
    @(negedge clk_i);
    wr_ni = 1'b1; rd_ni = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 0, 18'h3ffff, 2'b00);
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < DEPTH; a++) q.push_back('{a, ref_mem[a], tag});
    wait (q.size() == 0);
    #2;
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 'x;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    // fill, chaining each command on the previous final beat (R4, R5)
    step(1'b0, 1'b1, 0, 18'h0, 2'b00);
    for (int g = 0; g < DEPTH / 4; g++)
      for (int k = 0; k < 4; k++)
        step((k == 3 && g < DEPTH / 4 - 1) ? 1'b0 : 1'b1, 1'b1, (g + 1) * 4,
             18'(g * 4 + k + 18'h100), 2'b00);
    idle(2);
    check_all("R5_fill");

    // unaligned base wraps in group (R5)
    step(1'b0, 1'b1, 14, 18'h15555, 2'b00);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 0, 18'(18'h2a000 + k), 2'b00);
    idle(1);
    check_all("R5_wrap");

    // per-lane masks (R6) and mixed per beat (R7)
    step(1'b0, 1'b1, 32, 0, 2'b00);
    step(1'b1, 1'b1, 0, 18'h3ffff, 2'b01);
    step(1'b1, 1'b1, 0, 18'h3ffff, 2'b10);
    step(1'b1, 1'b1, 0, 18'h3ffff, 2'b11);
    step(1'b1, 1'b1, 0, 18'h3ffff, 2'b00);
    idle(1);
    check_all("R6");
    step(1'b0, 1'b1, 37, 0, 2'b00);
    step(1'b1, 1'b1, 0, 18'h12345, 2'b11);
    step(1'b1, 1'b1, 0, 18'h0abcd, 2'b00);
    step(1'b1, 1'b1, 0, 18'h00fff, 2'b10);
    step(1'b1, 1'b1, 0, 18'h3f000, 2'b01);
    idle(1);
    check_all("R7");

    // nop / read / both-low with live data (R1)
    step(1'b1, 1'b1, 8, 18'h00001, 2'b00);
    step(1'b1, 1'b0, 9, 18'h00002, 2'b00);
    step(1'b0, 1'b0, 10, 18'h00003, 2'b00);
    idle(5);
    check_all("R1");

    // read and both-low inside a burst (R2)
    step(1'b0, 1'b1, 16, 18'h0, 2'b00);
    step(1'b1, 1'b0, 40, 18'h11111, 2'b00);
    step(1'b0, 1'b0, 44, 18'h22222, 2'b00);
    step(1'b1, 1'b0, 48, 18'h33333, 2'b00);
    step(1'b1, 1'b1, 0, 18'h04444, 2'b00);
    idle(5);
    check_all("R2");

    // write strobe right after a write is ignored (R3)
    step(1'b0, 1'b1, 48, 18'h0, 2'b00);
    step(1'b0, 1'b1, 56, 18'h1a1a1, 2'b00);
    step(1'b1, 1'b1, 0, 18'h1b1b1, 2'b00);
    step(1'b1, 1'b1, 0, 18'h1c1c1, 2'b00);
    step(1'b1, 1'b1, 0, 18'h1d1d1, 2'b00);
    idle(5);
    check_all("R3");

    // ignored on beats 2,3; accepted on beat 4 and chained (R4)
    step(1'b0, 1'b1, 24, 18'h0, 2'b00);
    step(1'b1, 1'b1, 0, 18'h2e001, 2'b00);
    step(1'b0, 1'b1, 60, 18'h2e002, 2'b00);
    step(1'b0, 1'b1, 52, 18'h2e003, 2'b00);
    step(1'b0, 1'b1, 4, 18'h2e004, 2'b00);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 0, 18'(18'h31000 + k), 2'b00);
    idle(5);
    check_all("R4");

    // reset mid-burst keeps memory, drops remaining beats (R8)
    step(1'b0, 1'b1, 20, 18'h0, 2'b00);
    step(1'b1, 1'b1, 0, 18'h0a0a0, 2'b00);
    step(1'b1, 1'b1, 0, 18'h0b0b0, 2'b00);
    rst_ni = 1'b0; rem = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 0, 18'h0c0c0, 2'b00);
    step(1'b1, 1'b1, 0, 18'h0d0d0, 2'b00);
    idle(2);
    check_all("R8");

    // combinational debug read: change address without a clock edge (R9)
    #1;
    dbg_addr_i = 6'd33;
    #1;
    n_run++;
    if (dbg_data_o !== ref_mem[33]) begin
      n_fail++;
      $display("FAIL R9 actual=%h expected=%h", dbg_data_o, ref_mem[33]);
    end
    dbg_addr_i = 6'd14;
    #1;
    n_run++;
    if (dbg_data_o !== ref_mem[14]) begin
      n_fail++;
      $display("FAIL R9 actual=%h expected=%h", dbg_data_o, ref_mem[14]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule